// File: doc/BRIEF.md
# Watch Stepping Motor Pulse Generator

This block produces the drive waveform for a two-terminal bipolar stepping motor in a timepiece, clocked directly by a 32768 Hz timebase. A static 8-bit configuration word sets four things: how often the motor steps, how long each step pulse lasts, whether the pulse is driven solid or chopped, and whether a weaker tail segment follows the pulse. Each step pulses the terminal opposite to the one pulsed before it. Between steps both terminals sit high, so the winding is shorted.

Two raw control inputs pass through on-chip filters before they take effect. The halt request stops stepping and releases both terminals to high impedance. The fast-step request shortens the step interval to 1/32 s so that the mechanics can be exercised quickly. When a halt is lifted, the motor waits one full interval and then steps on the terminal opposite to the last one it drove. Time setting uses this: the hands can be stopped and then restarted in step.

The configuration word is decoded as follows. Bits [2:0] are the width code, bits [5:3] the interval code, bit 6 selects solid drive (1) or chopped drive (0), and bit 7 enables the tail segment.

Top module: `mstep_drive`

## Requirements
- R1: While reset is held, and right after it, `drv_en`, `drv_a` and `drv_b` are all 1. The first step comes on terminal A (`drv_a` low) one interval after reset is released.
- R2: Steps alternate terminals: A, B, A, ... The two drive outputs are never low at the same time.
- R3: While running, with `drv_en` at 1, every cycle outside the on-phases of a step has both `drv_a` and `drv_b` at 1.
- R4: Interval code (bits [5:3]) 000, 001, 010, 011 and 100 give an interval of 1, 5, 10, 20 and 30 times SEC_CYCLES cycles.
- R5: The width code (bits [2:0]) gives a primary pulse of (code+1) × STEP_CYCLES cycles.
- R6: With bit 6 at 1 the primary pulse is low for every cycle. With bit 6 at 0 it is low for the first 6 of each 8 cycles, giving 75 % on-time.
- R7: With bit 7 at 1, a tail segment follows the primary pulse. The tail lasts twice the primary width, drives the same terminal, and is low for the first 2 of each 8 cycles.
- R8: A halt request is filtered. Once the request is held steady, it takes effect more than SEC_CYCLES/32 cycles and no more than SEC_CYCLES/16 + 2 cycles later; release is filtered the same way. While halted, `drv_en` is 0, both drive outputs read 1, and no step occurs.
- R9: After a halt is lifted, the next step starts exactly one interval after `drv_en` returns to 1, on the terminal opposite to the last step before the halt.
- R10: In fast-step mode, after the same filtering, the interval is SEC_CYCLES/32 cycles. A step (primary plus tail) longer than that interval is cut to the interval.
- R11: Interval codes 101, 110 and 111 behave as code 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32768 Hz timebase |
| rst | input | 1 | Synchronous active-high reset |
| cfg | input | 8 | Static configuration word |
| stop_req | input | 1 | Raw halt request, active high |
| test_req | input | 1 | Raw fast-step request, active high |
| drv_a | output | 1 | Terminal A drive, low = driven step |
| drv_b | output | 1 | Terminal B drive, low = driven step |
| drv_en | output | 1 | Output switches closed when 1 |

## Verification
Outputs are registered once after the interval counter. The first low on `drv_a` therefore appears exactly interval+1 cycles after reset release. After a halt is lifted, `drv_b` goes low exactly one interval after the first cycle in which `drv_en` reads 1. The bench samples at falling edges and counts edges up to those points. The filters have no fixed phase, so for them the bench checks both limits of the acceptance window: the output is unchanged one filter tick after the request, and has taken effect by two ticks plus margin. Pulse shaping is measured as the total number of driven cycles across one whole interval, which does not depend on where the measurement window starts.

// File: rtl/mstep_pkg.sv
package mstep_pkg;

    typedef struct packed {
        logic       tail_en;
        logic       solid;
        logic [2:0] per_code;
        logic [2:0] wid_code;
    } cfg_t;

    typedef enum logic [1:0] {
        SEG_REST,
        SEG_MAIN,
        SEG_TAIL
    } seg_e;

    localparam logic [2:0] MAIN_ON = 3'd6;
    localparam logic [2:0] TAIL_ON = 3'd2;
    localparam int FAST_DIV = 32;

    function automatic logic [4:0] per_mult(input logic [2:0] code);
        case (code)
            3'd0:    per_mult = 5'd1;
            3'd1:    per_mult = 5'd5;
            3'd2:    per_mult = 5'd10;
            3'd3:    per_mult = 5'd20;
            3'd4:    per_mult = 5'd30;
            default: per_mult = 5'd1;
        endcase
    endfunction

endpackage

// File: rtl/mstep_filter.sv
module mstep_filter #(
    parameter int DEB = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic clean
);
    localparam int TW = (DEB > 1) ? $clog2(DEB) : 1;

    logic [TW-1:0] tcnt;
    logic          smp;
    logic          tick;

    assign tick = (tcnt == TW'(DEB - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt  <= '0;
            smp   <= 1'b0;
            clean <= 1'b0;
        end else begin
            tcnt <= tick ? '0 : tcnt + TW'(1);
            if (tick) begin
                smp <= raw;
                if (raw == smp) clean <= raw;
            end
        end
    end
endmodule

// File: rtl/mstep_timer.sv
module mstep_timer #(
    parameter int CW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          halt,
    input  logic [CW-1:0] per_len,
    output logic [CW-1:0] cnt,
    output logic          pol,
    output logic          quiet
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            pol   <= 1'b1;
            quiet <= 1'b1;
        end else if (halt) begin
            cnt   <= '0;
            quiet <= 1'b1;
        end else if (cnt >= per_len - CW'(1)) begin
            cnt   <= '0;
            quiet <= 1'b0;
            pol   <= ~pol;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/mstep_shaper.sv
module mstep_shaper
    import mstep_pkg::*;
#(
    parameter int CW          = 20,
    parameter int STEP_CYCLES = 32
) (
    input  cfg_t          cfg,
    input  logic          fast,
    input  logic          quiet,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] per_len,
    output logic          on
);
    logic [CW-1:0] wlen;
    logic [CW-1:0] plen;
    seg_e          seg;

    always_comb begin
        wlen = (CW'(cfg.wid_code) + CW'(1)) * CW'(STEP_CYCLES);
        plen = cfg.tail_en ? CW'(3) * wlen : wlen;
        if (fast && plen > per_len) plen = per_len;

        if (quiet || cnt >= plen) seg = SEG_REST;
        else if (cnt < wlen)      seg = SEG_MAIN;
        else                      seg = SEG_TAIL;

        case (seg)
            SEG_MAIN: on = cfg.solid || (cnt[2:0] < MAIN_ON);
            SEG_TAIL: on = (cnt[2:0] < TAIL_ON);
            default:  on = 1'b0;
        endcase
    end
endmodule

// File: rtl/mstep_drive.sv
module mstep_drive
    import mstep_pkg::*;
#(
    parameter int SEC_CYCLES  = 32768,
    parameter int STEP_CYCLES = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] cfg,
    input  logic       stop_req,
    input  logic       test_req,
    output logic       drv_a,
    output logic       drv_b,
    output logic       drv_en
);
    localparam int FAST_CYCLES = SEC_CYCLES / FAST_DIV;
    localparam int DEB_CYCLES  = SEC_CYCLES / FAST_DIV;
    localparam int MAX_PER     = 30 * SEC_CYCLES;
    localparam int CW          = $clog2(MAX_PER + 1);

    cfg_t          c;
    logic [1:0]    raw_in;
    logic [1:0]    filt;
    logic          halt;
    logic          fast;
    logic [CW-1:0] per_len;
    logic [CW-1:0] cnt;
    logic          pol;
    logic          quiet;
    logic          on;

    assign c      = cfg_t'(cfg);
    assign raw_in = {test_req, stop_req};
    assign halt   = filt[0];
    assign fast   = filt[1];

    for (genvar g = 0; g < 2; g++) begin : g_filt
        mstep_filter #(.DEB(DEB_CYCLES)) i_filt (
            .clk  (clk),
            .rst  (rst),
            .raw  (raw_in[g]),
            .clean(filt[g])
        );
    end

    always_comb begin
        if (fast) per_len = CW'(FAST_CYCLES);
        else      per_len = CW'(per_mult(c.per_code)) * CW'(SEC_CYCLES);
    end

    mstep_timer #(.CW(CW)) i_timer (
        .clk    (clk),
        .rst    (rst),
        .halt   (halt),
        .per_len(per_len),
        .cnt    (cnt),
        .pol    (pol),
        .quiet  (quiet)
    );

    mstep_shaper #(.CW(CW), .STEP_CYCLES(STEP_CYCLES)) i_shaper (
        .cfg    (c),
        .fast   (fast),
        .quiet  (quiet),
        .cnt    (cnt),
        .per_len(per_len),
        .on     (on)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_en <= 1'b1;
            drv_a  <= 1'b1;
            drv_b  <= 1'b1;
        end else begin
            drv_en <= ~halt;
            drv_a  <= ~(on && !pol && !halt);
            drv_b  <= ~(on && pol && !halt);
        end
    end
endmodule

// File: rtl/mstep_drive_chk.sv
module mstep_drive_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] cfg,
    input logic       stop_req,
    input logic       drv_a,
    input logic       drv_b,
    input logic       drv_en
);
    logic [7:0] run;

    always_ff @(posedge clk) begin
        if (rst)                    run <= '0;
        else if (!drv_a || !drv_b)  run <= (run == 8'hFF) ? run : run + 8'd1;
        else                        run <= '0;
    end

    p_never_both_r2: assert property (@(posedge clk) disable iff (rst)
        !(!drv_a && !drv_b));

    p_halt_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !drv_en |-> (drv_a && drv_b));

    p_halt_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(drv_en) |-> $past(stop_req, 2));

    p_release_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(drv_en) |-> !$past(stop_req, 2));

    p_release_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(drv_en) |=> (drv_a && drv_b));

    p_chop_run_r6: assert property (@(posedge clk) disable iff (rst)
        (!cfg[6] && $stable(cfg)) |-> (run <= 8'd6));
endmodule

bind mstep_drive mstep_drive_chk i_chk (
    .clk     (clk),
    .rst     (rst),
    .cfg     (cfg),
    .stop_req(stop_req),
    .drv_a   (drv_a),
    .drv_b   (drv_b),
    .drv_en  (drv_en)
);

// File: tb/test_mstep_drive.sv
module test_mstep_drive;
    localparam int CLK_PERIOD = 10;
    localparam int SEC  = 2048;
    localparam int STEP = 16;
    localparam int DEB  = SEC / 32;
    localparam int TP   = SEC / 32;
    localparam int WATCHDOG = 190000;

    typedef struct packed {
        logic [7:0]  cfg;
        logic [31:0] per;
        logic [31:0] on;
    } vec_t;

    // cfg = {tail, solid, per[2:0], wid[2:0]}
    localparam vec_t VECS [7] = '{
        '{8'h40, 32'd2048,  32'd16},
        '{8'h03, 32'd2048,  32'd48},
        '{8'hC7, 32'd2048,  32'd192},
        '{8'h81, 32'd2048,  32'd40},
        '{8'h4A, 32'd10240, 32'd48},
        '{8'h78, 32'd2048,  32'd16},
        '{8'h94, 32'd20480, 32'd100}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cfg = 8'h40;
    logic       stop_req = 1'b0;
    logic       test_req = 1'b0;
    logic       drv_a, drv_b, drv_en;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int n, m, onc, bad;

    mstep_drive #(.SEC_CYCLES(SEC), .STEP_CYCLES(STEP)) i_mstep_drive (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg),
        .stop_req(stop_req),
        .test_req(test_req),
        .drv_a   (drv_a),
        .drv_b   (drv_b),
        .drv_en  (drv_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements) actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [7:0] c, input bit chk_r1);
        rst = 1'b1;
        cfg = c;
        stop_req = 1'b0;
        test_req = 1'b0;
        repeat (3) @(negedge clk);
        if (chk_r1)
            chk(drv_en && drv_a && drv_b, "R1 reset state", {drv_en, drv_a, drv_b}, 7);
        rst = 1'b0;
    endtask

    initial begin
        // Vector walk: R1..R7, R11
        for (int i = 0; i < 7; i++) begin
            do_reset(VECS[i].cfg, i == 0);
            n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (drv_a && n < int'(VECS[i].per) + 8);
            chk(n == int'(VECS[i].per) + 1, "R4 R11 R1 first step delay on A", n, int'(VECS[i].per) + 1);
            onc = 1;
            bad = 0;
            for (int k = 1; k < int'(VECS[i].per); k++) begin
                @(negedge clk);
                if (!drv_a) onc++;
                if (!drv_b || !drv_en) bad++;
            end
            chk(onc == int'(VECS[i].on), "R5 R6 R7 driven cycles per step", onc, int'(VECS[i].on));
            chk(bad == 0, "R3 other terminal idle, enabled", bad, 0);
            @(negedge clk);
            chk(!drv_b && drv_a, "R2 next step on B after one interval", {drv_a, drv_b}, 2);
        end

        // Halt and restart: R8, R9
        do_reset(8'h40, 1'b0);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (drv_a && n < SEC + 8);
        repeat (20) @(negedge clk);
        stop_req = 1'b1;
        repeat (DEB) @(negedge clk);
        chk(drv_en == 1'b1, "R8 halt not taken before one filter tick", drv_en, 1);
        repeat (DEB + 4) @(negedge clk);
        chk(!drv_en && drv_a && drv_b, "R8 halted outputs", {drv_en, drv_a, drv_b}, 3);
        bad = 0;
        for (int k = 0; k < SEC + 64; k++) begin
            @(negedge clk);
            if (!drv_a || !drv_b || drv_en) bad++;
        end
        chk(bad == 0, "R8 no step while halted", bad, 0);
        stop_req = 1'b0;
        n = 0;
        while (!drv_en && n < 3 * DEB) begin
            @(negedge clk);
            n++;
        end
        chk(n > DEB && n <= 2 * DEB + 2, "R8 release filter delay", n, 2 * DEB);
        m = 0;
        bad = 0;
        do begin
            @(negedge clk);
            m++;
            if (!drv_a) bad++;
        end while (drv_b && m < SEC + 8);
        chk(m == SEC, "R9 restart one interval after release", m, SEC);
        chk(bad == 0 && !drv_b, "R9 restart on opposite terminal", bad, 0);

        // Fast-step mode with clamp: R10
        do_reset(8'hC7, 1'b0);
        test_req = 1'b1;
        repeat (4 * DEB) @(negedge clk);
        n = 0;
        while (!drv_a && n < 400) begin
            @(negedge clk);
            n++;
        end
        while (drv_a && n < 800) begin
            @(negedge clk);
            n++;
        end
        onc = 1;
        bad = 0;
        for (int k = 1; k < TP; k++) begin
            @(negedge clk);
            if (!drv_a) onc++;
            if (!drv_b) bad++;
        end
        chk(onc == TP, "R10 step clamped to fast interval", onc, TP);
        chk(bad == 0, "R10 B idle during A step", bad, 0);
        @(negedge clk);
        chk(!drv_b && drv_a, "R10 fast interval length", {drv_a, drv_b}, 2);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule